// File: doc/BRIEF.md
# Four-Mode Microcontroller Serial Port

A byte-oriented serial port of the traditional microcontroller kind. A two-bit mode field selects how it works. Mode 0 is a synchronous shifter: the data pin carries bits in either direction and the transmit pin supplies the shift clock. Mode 1 is an asynchronous link with ten bits per frame. Modes 2 and 3 are asynchronous links with eleven bits per frame, and the ninth bit can be set by software. Mode 2 runs from a fixed fraction of the core clock. Modes 1 and 3 take their timing from an external tick that a baud generator or timer supplies.

Software uses a single byte-wide register port. Address 0 is the control byte. Address 1 is the data buffer. A write to address 1 sends the byte. A read of address 1 returns the last byte that was received. The transmit-done flag and the receive-done flag are set by hardware and cleared only by software. The data pin has an open-drain driver: the block can only pull it low. In the asynchronous modes the block only samples it.

Top module: `mcu_serial_port`

## Requirements
- R1: Mode 0 transmit puts eight bits on the data pin, LSB first. A 0 bit is sent by pulling the pin low. Each bit lasts 12 clocks. The transmit pin is low for the first 6 of those clocks and high for the last 6. The transmit flag (control bit 6) is set after the eighth bit.
- R2: Mode 0 receive starts only while the enable bit (control bit 3) is 1 and the receive flag (control bit 7) is 0. It samples the data pin on each rising edge of the shift clock, LSB first. After eight bits it sets the receive flag and the byte is readable at address 1.
- R3: A mode 1 transmit frame is a 0 start bit, eight data bits LSB first, and a 1 stop bit, each lasting 16 external ticks. The transmit flag is set when the stop bit begins.
- R4: Mode 1 receive stores the received stop bit in control bit 5 and the data byte in the buffer, and sets the receive flag.
- R5: Modes 2 and 3 send eleven bits: start, eight data bits LSB first, control bit 4 as the ninth bit, then stop. In mode 2 one bit lasts 64 clocks when control bit 2 is 0, and 32 clocks when it is 1.
- R6: In modes 2 and 3 the received ninth bit is stored in control bit 5.
- R7: Mode 3 uses the mode 2 frame, timed at 16 external ticks per bit.
- R8: While the enable bit is 0, an asynchronous frame on the data pin leaves the receive flag and the buffer unchanged.
- R9: A start bit that reads high at mid-bit, by a three-sample majority vote, is dropped. The receiver goes back to idle and then accepts the next valid frame.
- R10: A frame that completes while the receive flag is already set is discarded, and the buffer keeps its old byte.
- R11: The transmit and receive flags stay set until software writes them to 0.
- R12: In modes 1 to 3 the transmit pin is high whenever no frame is being sent, and the block never pulls the data pin low.
- R13: After reset the control byte reads 0x00, the transmit pin is high and the data pin is released. The mode field is control bits 1:0, with values 0 to 3 for modes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control byte, 1 = data buffer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| baud_tick | input | 1 | External tick at 16 times the bit rate (modes 1 and 3) |
| dat_in | input | 1 | Level seen on the data pin |
| dat_pull_low | output | 1 | Pulls the data pin low when 1 |
| txd | output | 1 | Serial output, or the shift clock in mode 0 |

## Verification
A wrong bit counter or shift register shows up at the pins within one frame. The frame then has the wrong number of bits, or the ninth bit lands where the stop bit belongs, and the bit-by-bit frame monitor catches either case at the next mid-bit sample. A corrupt tick or phase counter moves the moment the transmit flag rises, which the bench measures against the bit period to within one tick. A receiver stuck outside idle, or one that leaked a glitch through, leaves a wrong receive flag or buffer value. This becomes visible one frame later, when the next valid frame is read back.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_SHIFT    = 2'd0,
        MODE_A8       = 2'd1,
        MODE_A9_FIXED = 2'd2,
        MODE_A9_EXT   = 2'd3
    } mode_e;

    typedef struct packed {
        logic  ri;
        logic  ti;
        logic  rb8;
        logic  tb8;
        logic  ren;
        logic  fast;
        mode_e mode;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ASYNC,
        RX_SHIFT
    } rx_state_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic is_nine(input mode_e m);
        return (m == MODE_A9_FIXED) || (m == MODE_A9_EXT);
    endfunction

endpackage

// File: rtl/msp_rate.sv
module msp_rate
    import msp_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int SLOW_BIT   = 64,
    parameter int FAST_BIT   = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  fast,
    input  logic  baud_tick,
    output logic  tick
);
    localparam int SLOW_DIV = SLOW_BIT / OVERSAMPLE;
    localparam int FAST_DIV = FAST_BIT / OVERSAMPLE;
    localparam int CW       = $clog2(SLOW_DIV + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim = fast ? CW'(FAST_DIV) : CW'(SLOW_DIV);

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_A9_FIXED) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim - 1'b1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (mode == MODE_A9_FIXED) ? (cnt_q == lim - 1'b1)
                                          : (mode != MODE_SHIFT && baud_tick);
endmodule

// File: rtl/msp_tx.sv
module msp_tx
    import msp_pkg::*;
#(
    parameter int SHIFT_DIV  = 12,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              tb8,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              tick,
    output logic              line,
    output logic              pull_low,
    output logic              busy,
    output logic              ti_set
);
    localparam int PW    = $clog2(SHIFT_DIV);
    localparam int TW    = $clog2(OVERSAMPLE);
    localparam int FRAME = BYTE_W + 3;

    logic             busy_q;
    logic [FRAME-1:0] sr_q;
    logic [3:0]       bidx_q;
    logic [3:0]       last_q;
    logic [TW-1:0]    tcnt_q;
    logic [PW-1:0]    phase_q;
    logic             sync_mode;
    logic             bit_end;
    logic             sclk;

    assign sync_mode = (mode == MODE_SHIFT);
    assign bit_end   = busy_q && (sync_mode ? (phase_q == PW'(SHIFT_DIV - 1))
                                            : (tick && tcnt_q == TW'(OVERSAMPLE - 1)));
    assign ti_set    = bit_end && (sync_mode ? (bidx_q == last_q)
                                             : (bidx_q == last_q - 4'd1));
    assign sclk      = (phase_q >= PW'(SHIFT_DIV / 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sr_q    <= '1;
            bidx_q  <= '0;
            last_q  <= '0;
            tcnt_q  <= '0;
            phase_q <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            sr_q    <= sync_mode ? {3'b111, din}
                                 : {1'b1, (is_nine(mode) ? tb8 : 1'b1), din, 1'b0};
            last_q  <= sync_mode ? 4'd7 : (is_nine(mode) ? 4'd10 : 4'd9);
            bidx_q  <= '0;
            tcnt_q  <= '0;
            phase_q <= '0;
        end else if (busy_q) begin
            if (sync_mode) begin
                phase_q <= (phase_q == PW'(SHIFT_DIV - 1)) ? '0 : phase_q + 1'b1;
            end
            if (tick) begin
                tcnt_q <= tcnt_q + 1'b1;
            end
            if (bit_end) begin
                sr_q   <= {1'b1, sr_q[FRAME-1:1]};
                bidx_q <= bidx_q + 4'd1;
                if (bidx_q == last_q) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign line     = !busy_q ? 1'b1 : (sync_mode ? sclk : sr_q[0]);
    assign pull_low = busy_q && sync_mode && !sr_q[0];
endmodule

// File: rtl/msp_rx.sv
module msp_rx
    import msp_pkg::*;
#(
    parameter int SHIFT_DIV  = 12,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              ren,
    input  logic              ri,
    input  logic              tx_busy,
    input  logic              pin,
    input  logic              tick,
    output logic              done,
    output logic [BYTE_W-1:0] data,
    output logic              bit9,
    output logic              busy,
    output logic              sclk
);
    localparam int PW    = $clog2(SHIFT_DIV);
    localparam int TW    = $clog2(OVERSAMPLE);
    localparam int MID   = OVERSAMPLE / 2;
    localparam int S_MID = SHIFT_DIV / 2;

    rx_state_e         state_q;
    logic [1:0]        sync_q;
    logic [BYTE_W-1:0] data_q;
    logic              nine_q;
    logic [3:0]        bidx_q;
    logic [TW-1:0]     tcnt_q;
    logic [PW-1:0]     phase_q;
    logic [1:0]        votes_q;
    logic              s_in;
    logic [TW-1:0]     idx;
    logic              v;
    logic [3:0]        last_idx;
    logic              decide;

    assign s_in     = sync_q[1];
    assign idx      = tcnt_q + 1'b1;
    assign v        = vote3({votes_q, s_in});
    assign last_idx = is_nine(mode) ? 4'd10 : 4'd9;
    assign decide   = (state_q == RX_ASYNC) && tick && (idx == TW'(MID + 1));

    assign done = (decide && bidx_q == last_idx) ||
                  (state_q == RX_SHIFT && phase_q == PW'(SHIFT_DIV - 1) && bidx_q == 4'd7);
    assign bit9 = (mode == MODE_A8) ? v : nine_q;
    assign data = data_q;
    assign busy = (state_q != RX_IDLE);
    assign sclk = !(state_q == RX_SHIFT && phase_q < PW'(S_MID));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            state_q <= RX_IDLE;
            data_q  <= '0;
            nine_q  <= 1'b0;
            bidx_q  <= '0;
            tcnt_q  <= '0;
            phase_q <= '0;
            votes_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin};
            unique case (state_q)
                RX_IDLE: begin
                    bidx_q  <= '0;
                    tcnt_q  <= '0;
                    phase_q <= '0;
                    if (mode == MODE_SHIFT) begin
                        if (ren && !ri && !tx_busy) begin
                            state_q <= RX_SHIFT;
                        end
                    end else if (ren && tick && !s_in) begin
                        state_q <= RX_ASYNC;
                    end
                end
                RX_ASYNC: begin
                    if (tick) begin
                        tcnt_q <= idx;
                        if (idx == TW'(MID - 1) || idx == TW'(MID)) begin
                            votes_q <= {votes_q[0], s_in};
                        end
                        if (idx == '0) begin
                            bidx_q <= bidx_q + 4'd1;
                        end
                        if (decide) begin
                            if (bidx_q == 4'd0 && v) begin
                                state_q <= RX_IDLE;
                            end else if (bidx_q >= 4'd1 && bidx_q <= 4'd8) begin
                                data_q <= {v, data_q[BYTE_W-1:1]};
                            end else if (bidx_q == 4'd9 && is_nine(mode)) begin
                                nine_q <= v;
                            end
                            if (bidx_q == last_idx) begin
                                state_q <= RX_IDLE;
                            end
                        end
                    end
                end
                RX_SHIFT: begin
                    phase_q <= (phase_q == PW'(SHIFT_DIV - 1)) ? '0 : phase_q + 1'b1;
                    if (phase_q == PW'(S_MID)) begin
                        data_q <= {s_in, data_q[BYTE_W-1:1]};
                    end
                    if (phase_q == PW'(SHIFT_DIV - 1)) begin
                        bidx_q <= bidx_q + 4'd1;
                        if (bidx_q == 4'd7) begin
                            state_q <= RX_IDLE;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
    import msp_pkg::*;
#(
    parameter int SHIFT_DIV  = 12,
    parameter int OVERSAMPLE = 16,
    parameter int SLOW_BIT   = 64,
    parameter int FAST_BIT   = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       baud_tick,
    input  logic       dat_in,
    output logic       dat_pull_low,
    output logic       txd
);
    ctrl_t             ctrl_q, ctrl_n;
    logic [BYTE_W-1:0] rbuf_q, rbuf_n;
    logic              tick;
    logic              tx_line, tx_pull, tx_busy, tx_ti;
    logic              rx_done, rx_bit9, rx_busy, rx_sclk;
    logic [BYTE_W-1:0] rx_data;

    msp_rate #(
        .OVERSAMPLE(OVERSAMPLE), .SLOW_BIT(SLOW_BIT), .FAST_BIT(FAST_BIT)
    ) u_rate (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .fast(ctrl_q.fast),
        .baud_tick(baud_tick), .tick(tick)
    );

    msp_tx #(.SHIFT_DIV(SHIFT_DIV), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .tb8(ctrl_q.tb8),
        .load(we && addr), .din(wdata), .tick(tick),
        .line(tx_line), .pull_low(tx_pull), .busy(tx_busy), .ti_set(tx_ti)
    );

    msp_rx #(.SHIFT_DIV(SHIFT_DIV), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .ren(ctrl_q.ren),
        .ri(ctrl_q.ri), .tx_busy(tx_busy), .pin(dat_in), .tick(tick),
        .done(rx_done), .data(rx_data), .bit9(rx_bit9),
        .busy(rx_busy), .sclk(rx_sclk)
    );

    always_comb begin
        ctrl_n = (we && !addr) ? ctrl_t'(wdata) : ctrl_q;
        rbuf_n = rbuf_q;
        if (tx_ti) begin
            ctrl_n.ti = 1'b1;
        end
        if (rx_done && !ctrl_q.ri) begin
            ctrl_n.ri = 1'b1;
            rbuf_n    = rx_data;
            if (ctrl_q.mode != MODE_SHIFT) begin
                ctrl_n.rb8 = rx_bit9;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rbuf_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            rbuf_q <= rbuf_n;
        end
    end

    assign rdata        = addr ? rbuf_q : ctrl_q;
    assign txd          = (ctrl_q.mode == MODE_SHIFT && rx_busy) ? rx_sclk : tx_line;
    assign dat_pull_low = tx_pull;
endmodule

// File: rtl/mcu_serial_port_chk.sv
module mcu_serial_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       we,
    input logic       addr,
    input logic [1:0] mode,
    input logic       ren,
    input logic       ri,
    input logic       ti,
    input logic       tx_busy,
    input logic       rx_busy,
    input logic       rx_done,
    input logic       txd,
    input logic       dat_pull_low
);
    p_async_no_pull_r12: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0) |-> !dat_pull_low);

    p_async_idle_high_r12: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && !tx_busy) |-> txd);

    p_ti_sw_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ti) |-> $past(we && !addr));

    p_ri_sw_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ri) |-> $past(we && !addr));

    p_m0_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_busy) && mode == 2'd0) |-> $past(ren && !ri));

    p_ri_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ri) |-> $past(rx_done || (we && !addr)));

    p_ti_on_stop_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(ti) && mode != 2'd0 && !$past(we && !addr)) |-> txd);
endmodule

bind mcu_serial_port mcu_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .mode(ctrl_q.mode),
    .ren(ctrl_q.ren), .ri(ctrl_q.ri), .ti(ctrl_q.ti),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_done(rx_done),
    .txd(txd), .dat_pull_low(dat_pull_low)
);

// File: tb/sim_mcu_serial_port.sv
module sim_mcu_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam int BDIV       = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       baud_tick = 1'b0;
    logic       ext_rx = 1'b1;
    logic       dat_pull_low;
    logic       txd;
    wire        dat_pin = ext_rx & ~dat_pull_low;

    int nvec = 0, nerr = 0, cyc = 0, bcnt = 0;
    int bitclk = 48, mon_nb = 10, mon_cnt = 0, mon_want = 0;
    logic mon_on = 1'b0;
    string mon_tag = "R3";
    logic [10:0] tx_q[$];
    logic [7:0]  rx_q[$];
    logic [10:0] got_fr, want_fr;

    mcu_serial_port u0 (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .baud_tick(baud_tick), .dat_in(dat_pin),
        .dat_pull_low(dat_pull_low), .txd(txd)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            bcnt = (bcnt == BDIV - 1) ? 0 : bcnt + 1;
            baud_tick = (bcnt == 0);
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int got, input int lo, input int hi);
        nvec++;
        if (got < lo || got > hi) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // async transmit monitor: decodes each frame and pops the scoreboard
    initial begin
        forever begin
            @(negedge txd);
            if (mon_on) begin
                got_fr = '1;
                repeat (bitclk / 2) @(negedge clk);
                got_fr[0] = txd;
                for (int i = 1; i < mon_nb; i++) begin
                    repeat (bitclk) @(negedge clk);
                    got_fr[i] = txd;
                end
                if (tx_q.size() == 0) begin
                    chk({mon_tag, " unexpected frame"}, 1, 0);
                end else begin
                    want_fr = tx_q.pop_front();
                    chk({mon_tag, " frame bits"}, int'(got_fr), int'(want_fr));
                end
                mon_cnt++;
            end
        end
    end

    task automatic tx_case(input string tag, input logic [7:0] ctl, input logic [7:0] d,
                           input int nb, input int bc, input int dv);
        int t0, el, n;
        logic [7:0] r;
        wr(1'b0, ctl);
        bitclk = bc; mon_nb = nb; mon_tag = tag; mon_on = 1'b1;
        tx_q.push_back({1'b1, (nb == 11) ? ctl[4] : 1'b1, d, 1'b0});
        mon_want++;
        wr(1'b1, d);
        t0 = cyc;
        addr = 1'b0;
        el = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            #1;
            if (rdata[6]) begin
                el = cyc - t0;
                break;
            end
        end
        n = (nb - 1) * 16 * dv;
        chk_rng({tag, " TI at stop bit start (cycles)"}, el, n - dv, n + 1);
        chk({tag, " txd high when TI rises"}, txd, 1);
        wait (mon_cnt == mon_want);
        repeat (bc) @(negedge clk);
        rd(1'b0, r);
        chk("R11 TI held until written", r[6], 1);
        wr(1'b0, ctl);
        rd(1'b0, r);
        chk("R11 TI cleared by write", r[6], 0);
        chk("R12 txd idle high", txd, 1);
        chk("R12 data pin released", dat_pull_low, 0);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic b9, input int nb, input int bc);
        ext_rx = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ext_rx = d[i];
            repeat (bc) @(negedge clk);
        end
        if (nb == 11) begin
            ext_rx = b9;
            repeat (bc) @(negedge clk);
        end
        ext_rx = 1'b1;
        repeat (2 * bc) @(negedge clk);
    endtask

    task automatic rx_expect(input string tag, input logic [7:0] d, input logic b9,
                             input int nb, input int bc);
        logic [7:0] r, e;
        rx_q.push_back(d);
        send_rx(d, b9, nb, bc);
        e = rx_q.pop_front();
        rd(1'b1, r);
        chk({tag, " buffer"}, r, e);
        rd(1'b0, r);
        chk({tag, " RI set"}, r[7], 1);
        chk({tag, " RB8"}, r[5], b9);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [7:0] r, b;
        int tr0, tr1;
        bit quiet;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(1'b0, r);
        chk("R13 control after reset", r, 8'h00);
        chk("R13 txd after reset", txd, 1);
        chk("R13 data pin after reset", dat_pull_low, 0);

        // asynchronous transmit: mode 1, mode 2 slow and fast, mode 3
        tx_case("R3", 8'h01, 8'h5A, 10, 48, BDIV);
        tx_case("R5", 8'h12, 8'h3C, 11, 64, 4);
        tx_case("R5", 8'h06, 8'hC3, 11, 32, 2);
        tx_case("R7", 8'h13, 8'h81, 11, 48, BDIV);
        mon_on = 1'b0;

        // mode 0 transmit
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hA5);
        b = '0; tr0 = 0; tr1 = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge txd);
            if (k == 0) tr0 = cyc;
            if (k == 1) tr1 = cyc;
            #1;
            b[k] = dat_pin;
        end
        chk("R1 shifted byte", b, 8'hA5);
        chk("R1 shift clock period", tr1 - tr0, 12);
        repeat (20) @(negedge clk);
        rd(1'b0, r);
        chk("R1 TI after eighth bit", r[6], 1);
        wr(1'b0, 8'h00);

        // mode 0 receive held off while RI is set
        wr(1'b0, 8'h88);
        quiet = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!txd) quiet = 1'b0;
        end
        chk("R2 no shift clock while RI set", quiet, 1);

        // mode 0 receive
        wr(1'b0, 8'h08);
        for (int k = 0; k < 8; k++) begin
            @(negedge txd);
            ext_rx = b[k] ^ k[0] ^ 1'b1;
        end
        repeat (20) @(negedge clk);
        ext_rx = 1'b1;
        rd(1'b0, r);
        chk("R2 RI after receive", r[7], 1);
        rd(1'b1, r);
        chk("R2 received byte", r, 8'hA5 ^ 8'hAA ^ 8'hFF);
        wr(1'b0, 8'h00);

        // asynchronous receive
        wr(1'b0, 8'h09);
        rx_expect("R4", 8'h96, 1'b1, 10, 48);
        wr(1'b0, 8'h0A);
        rx_expect("R6", 8'h55, 1'b0, 11, 64);
        wr(1'b0, 8'h0B);
        rx_expect("R7", 8'hE1, 1'b1, 11, 48);

        // RI still set: next frame discarded
        send_rx(8'h12, 1'b0, 11, 48);
        rd(1'b1, r);
        chk("R10 buffer kept when RI set", r, 8'hE1);
        rd(1'b0, r);
        chk("R10 RB8 kept when RI set", r[5], 1);

        // receiver disabled
        wr(1'b0, 8'h03);
        send_rx(8'h77, 1'b0, 11, 48);
        rd(1'b0, r);
        chk("R8 RI stays clear when disabled", r[7], 0);
        rd(1'b1, r);
        chk("R8 buffer unchanged when disabled", r, 8'hE1);

        // false start, then a valid frame
        wr(1'b0, 8'h0A);
        ext_rx = 1'b0;
        repeat (20) @(negedge clk);
        ext_rx = 1'b1;
        repeat (100) @(negedge clk);
        rd(1'b0, r);
        chk("R9 glitch sets no RI", r[7], 0);
        rx_expect("R9", 8'h3E, 1'b1, 11, 64);
        chk("R12 data pin released in async", dat_pull_low, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule